// File: doc/BRIEF.md
# Segment-Aware Posted Store Queue

This block sits between a processor's load/store port and one external memory bus. It holds up to four word stores as posted writes and retires them to the bus in arrival order. Stores to the lower half of the address space and to the cached kernel window go into the queue. The CPU sees them complete at once, as long as a slot is free. Every other access goes straight to the bus, and so does every load.

Ordering is kept by three rules:

- An access to the uncached kernel window, read or write, waits until the queue is empty.
- A load whose word address matches a pending store waits until every matching entry has been written out. The stores queued ahead of that entry drain first, because the queue is a FIFO.
- A load that matches nothing may pass the pending stores. A store to the upper kernel window may also pass them.

Both sides use a valid/ready request channel. A load completes in the cycle the bus accepts it. Its data is `bus_rdata` in that same cycle.

Top module: `store_post_queue`

## Requirements
- R1: After reset, `queue_empty` is 1 and `bus_valid` is 0.
- R2: A store whose address bits [31:29] are 000 to 100 (address below A0000000h) is accepted with `cpu_ready`=1 whenever the queue is not full, whatever the state of `bus_ready`. The store is held in the queue.
- R3: An access whose address bits [31:29] are 101, 110 or 111 is never held in the queue. It is presented on the bus, and `cpu_ready` follows `bus_ready` once the access may proceed.
- R4: An access with address bits [31:29] = 101, read or write, is not issued until the queue is empty. All queued stores appear on the bus before it.
- R5: A load whose word address (address bits [31:2]) equals that of a queued store stalls with `cpu_ready`=0 until no such entry remains. It is then issued ahead of any younger queued stores.
- R6: Queued stores leave as bus writes (`bus_write`=1), one per accepted bus cycle, in arrival order, with their own address, data and byte enables. A queued-segment store presented while the queue is full is accepted in the same cycle that the oldest entry retires.
- R7: A load with no matching queued entry, or a store with address bits [31:29] = 110 or 111, is not an uncached-window access. Such an access takes the bus ahead of pending queued stores. For a load, `cpu_rdata` equals `bus_rdata` in the accept cycle.
- R8: When the queue holds four entries and no entry retires, a queued-segment store sees `cpu_ready`=0.
- R9: The load match ignores address bits [1:0].
- R10: `queue_empty` is 1 exactly when no store is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | CPU request accepted this cycle |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_rdata | output | 32 | Load data, valid in the accept cycle |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts request this cycle |
| bus_write | output | 1 | Bus request is a write |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_be | output | 4 | Bus byte enables |
| bus_rdata | input | 32 | Bus read data |
| queue_empty | output | 1 | No pending stores |

## Verification
Some rules are checked on every cycle:

- No uncached-window access is accepted while stores are pending.
- No load is accepted while it matches an entry.
- A full queue never takes a store unless an entry retires in the same cycle.
- Bypassing accesses never leave an entry behind.
- The queue never overflows or underflows.

Other behaviour only the bench's scenarios can show. This covers the order of transactions on the bus, the data returned to loads, and the acceptance of a store in the very cycle a full queue retires its head. It also covers the segment sweep over all eight values of the top address bits.

// File: rtl/spq_pkg.sv
package spq_pkg;
   typedef enum logic [1:0] {
      SEG_POSTED   = 2'd0,
      SEG_UNCACHED = 2'd1,
      SEG_DIRECT   = 2'd2
   } seg_e;
endpackage

// File: rtl/spq_seg_decode.sv
module spq_seg_decode
   import spq_pkg::*;
(
   input  logic [2:0] top_bits,
   output seg_e       seg
);
   always_comb begin
      unique case (top_bits)
         3'b101:         seg = SEG_UNCACHED;
         3'b110, 3'b111: seg = SEG_DIRECT;
         default:        seg = SEG_POSTED;
      endcase
   end
endmodule

// File: rtl/spq_fifo.sv
module spq_fifo #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BW    = 4,
   parameter int DEPTH = 4,
   parameter int OFF   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [AW-1:0]     push_addr,
   input  logic [DW-1:0]     push_data,
   input  logic [BW-1:0]     push_be,
   input  logic              pop,
   output logic [AW-1:0]     head_addr,
   output logic [DW-1:0]     head_data,
   output logic [BW-1:0]     head_be,
   output logic              empty,
   output logic              full,
   input  logic [AW-OFF-1:0] probe_word,
   output logic              probe_hit
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("spq_fifo: DEPTH must be at least 1");
   end

   logic [AW-1:0]    ent_a [DEPTH];
   logic [DW-1:0]    ent_d [DEPTH];
   logic [BW-1:0]    ent_b [DEPTH];
   logic [DEPTH-1:0] vld;
   logic [DEPTH-1:0] hit_v;
   logic [PW-1:0]    rd_p, wr_p;
   logic [CW-1:0]    cnt;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            ent_a[i] <= '0;
            ent_d[i] <= '0;
            ent_b[i] <= '0;
         end
         vld  <= '0;
         rd_p <= '0;
         wr_p <= '0;
         cnt  <= '0;
      end else begin
         if (pop) begin
            vld[rd_p] <= 1'b0;
            rd_p      <= bump(rd_p);
         end
         if (push) begin
            ent_a[wr_p] <= push_addr;
            ent_d[wr_p] <= push_data;
            ent_b[wr_p] <= push_be;
            vld[wr_p]   <= 1'b1;
            wr_p        <= bump(wr_p);
         end
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_match
      assign hit_v[i] = vld[i] && (ent_a[i][AW-1:OFF] == probe_word);
   end

   assign probe_hit = |hit_v;
   assign empty     = (cnt == '0);
   assign full      = (cnt == CW'(DEPTH));
   assign head_addr = ent_a[rd_p];
   assign head_data = ent_d[rd_p];
   assign head_be   = ent_b[rd_p];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop); // R8
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R6
endmodule

// File: rtl/spq_bus_arb.sv
module spq_bus_arb
   import spq_pkg::*;
(
   input  logic cpu_valid,
   input  logic cpu_write,
   input  seg_e seg,
   input  logic hit,
   input  logic q_empty,
   input  logic q_full,
   input  logic bus_ready,
   output logic sel_cpu,
   output logic bus_valid,
   output logic push,
   output logic pop,
   output logic cpu_ready
);
   logic posted_st, direct_req, blocked;

   always_comb begin
      posted_st  = cpu_valid && cpu_write && (seg == SEG_POSTED);
      direct_req = cpu_valid && !posted_st;
      blocked    = ((seg == SEG_UNCACHED) && !q_empty) || (!cpu_write && hit);
      sel_cpu    = direct_req && !blocked;
      bus_valid  = sel_cpu || !q_empty;
      pop        = !sel_cpu && !q_empty && bus_ready;
      push       = posted_st && (!q_full || pop);
      cpu_ready  = posted_st ? (!q_full || pop) : (sel_cpu && bus_ready);
   end
endmodule

// File: rtl/store_post_queue.sv
module store_post_queue
   import spq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_valid,
   output logic                cpu_ready,
   input  logic                cpu_write,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [DATA_W-1:0]   cpu_wdata,
   input  logic [DATA_W/8-1:0] cpu_be,
   output logic [DATA_W-1:0]   cpu_rdata,
   output logic                bus_valid,
   input  logic                bus_ready,
   output logic                bus_write,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W/8-1:0] bus_be,
   input  logic [DATA_W-1:0]   bus_rdata,
   output logic                queue_empty
);
   localparam int BW  = DATA_W / 8;
   localparam int OFF = (BW > 1) ? $clog2(BW) : 1;

   if ((DATA_W % 8) != 0 || DATA_W < 16) begin : g_bad_data
      $error("store_post_queue: DATA_W must be a multiple of 8, at least 16");
   end
   if (ADDR_W < OFF + 3) begin : g_bad_addr
      $error("store_post_queue: ADDR_W too small for segment decode");
   end

   seg_e seg;
   logic hit, q_empty, q_full, sel_cpu, push, pop;
   logic [ADDR_W-1:0] head_addr;
   logic [DATA_W-1:0] head_data;
   logic [BW-1:0]     head_be;

   spq_seg_decode u_dec (
      .top_bits (cpu_addr[ADDR_W-1 -: 3]),
      .seg      (seg)
   );

   spq_fifo #(.AW(ADDR_W), .DW(DATA_W), .BW(BW), .DEPTH(DEPTH), .OFF(OFF)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .push_addr  (cpu_addr),
      .push_data  (cpu_wdata),
      .push_be    (cpu_be),
      .pop        (pop),
      .head_addr  (head_addr),
      .head_data  (head_data),
      .head_be    (head_be),
      .empty      (q_empty),
      .full       (q_full),
      .probe_word (cpu_addr[ADDR_W-1:OFF]),
      .probe_hit  (hit)
   );

   spq_bus_arb u_arb (
      .cpu_valid (cpu_valid),
      .cpu_write (cpu_write),
      .seg       (seg),
      .hit       (hit),
      .q_empty   (q_empty),
      .q_full    (q_full),
      .bus_ready (bus_ready),
      .sel_cpu   (sel_cpu),
      .bus_valid (bus_valid),
      .push      (push),
      .pop       (pop),
      .cpu_ready (cpu_ready)
   );

   assign bus_write   = sel_cpu ? cpu_write : 1'b1;
   assign bus_addr    = sel_cpu ? cpu_addr  : head_addr;
   assign bus_wdata   = sel_cpu ? cpu_wdata : head_data;
   assign bus_be      = sel_cpu ? cpu_be    : head_be;
   assign cpu_rdata   = bus_rdata;
   assign queue_empty = q_empty;

   AST_UNCACHED_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && seg == SEG_UNCACHED) |-> queue_empty); // R4
   AST_LOAD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && !cpu_write) |-> !hit); // R5
   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_write && seg == SEG_POSTED && q_full && !bus_ready) |-> !cpu_ready); // R8
   AST_BYPASS_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && seg != SEG_POSTED && queue_empty) |=> queue_empty); // R3
endmodule

// File: tb/store_post_queue_tb_top.sv
module store_post_queue_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_valid = 1'b0;
   logic        cpu_ready;
   logic        cpu_write = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [3:0]  cpu_be = 4'hF;
   logic [31:0] cpu_rdata;
   logic        bus_valid;
   logic        bus_ready = 1'b0;
   logic        bus_write;
   logic [31:0] bus_addr;
   logic [31:0] bus_wdata;
   logic [3:0]  bus_be;
   logic [31:0] bus_rdata;
   logic        queue_empty;

   int total = 0;
   int bad = 0;

   logic [31:0] log_a [0:31];
   logic [31:0] log_d [0:31];
   logic        log_w [0:31];
   int          log_n = 0;

   always #2 clk = ~clk;

   assign bus_rdata = ~bus_addr;

   store_post_queue dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .cpu_rdata(cpu_rdata),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
      .queue_empty(queue_empty)
   );

   always begin
      @(negedge clk);
      #1;
      if (rst_n && bus_valid && bus_ready && log_n < 32) begin
         log_a[log_n] = bus_addr;
         log_d[log_n] = bus_wdata;
         log_w[log_n] = bus_write;
         log_n = log_n + 1;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // Called at a falling edge; returns at a later falling edge with valid dropped.
   task automatic cpu_op(input logic [31:0] a, input logic [31:0] d, input logic w,
                         output logic [31:0] rd, output int waits);
      waits = 0;
      cpu_valid = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_write = w; cpu_be = 4'hF;
      forever begin
         #1;
         if (cpu_ready) begin
            rd = cpu_rdata;
            break;
         end
         waits++;
         @(negedge clk);
      end
      @(negedge clk);
      cpu_valid = 1'b0;
   endtask

   task automatic chk_log(input string req, input int idx, input logic [31:0] a, input logic w);
      chk(req, $sformatf("log[%0d] addr", idx), log_a[idx], a);
      chk(req, $sformatf("log[%0d] write", idx), {31'b0, log_w[idx]}, {31'b0, w});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int waits;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "queue_empty after reset", {31'b0, queue_empty}, 32'd1);
      chk("R1", "bus_valid after reset", {31'b0, bus_valid}, 32'd0);
      chk("R10", "empty with no stores", {31'b0, queue_empty}, 32'd1);
      @(negedge clk);

      // Segment sweep over all eight top-bit values (R2, R3)
      for (int t = 0; t < 8; t++) begin
         logic [31:0] a;
         logic exp_post;
         a = {3'(t), 29'h40};
         exp_post = (t < 5);
         bus_ready = 1'b0;
         cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = a; cpu_wdata = 32'hA5A5_0000 + t;
         #1;
         chk(exp_post ? "R2" : "R3", $sformatf("seg %0d store ready", t), {31'b0, cpu_ready}, {31'b0, exp_post});
         chk(exp_post ? "R2" : "R3", $sformatf("seg %0d bus_valid", t), {31'b0, bus_valid}, {31'b0, !exp_post});
         @(negedge clk);
         if (exp_post) begin
            cpu_valid = 1'b0;
            #1;
            chk("R10", $sformatf("seg %0d queued not empty", t), {31'b0, queue_empty}, 32'd0);
            chk("R6", $sformatf("seg %0d head addr", t), bus_addr, a);
            @(negedge clk);
            bus_ready = 1'b1;
            @(negedge clk);
            bus_ready = 1'b0;
            #1;
            chk("R10", $sformatf("seg %0d drained empty", t), {31'b0, queue_empty}, 32'd1);
         end else begin
            chk("R3", $sformatf("seg %0d bus addr", t), bus_addr, a);
            bus_ready = 1'b1;
            #1;
            chk("R3", $sformatf("seg %0d ready follows bus", t), {31'b0, cpu_ready}, 32'd1);
            @(negedge clk);
            cpu_valid = 1'b0; bus_ready = 1'b0;
            #1;
            chk("R3", $sformatf("seg %0d not queued", t), {31'b0, queue_empty}, 32'd1);
         end
         @(negedge clk);
      end

      // FIFO drain order and full stall (R6, R8)
      log_n = 0;
      bus_ready = 1'b0;
      for (int k = 0; k < 4; k++) begin
         cpu_op(32'h0000_1000 + 32'(16 * k), 32'h1100 + 32'(k), 1'b1, rd, waits);
         chk("R2", $sformatf("store %0d no wait", k), 32'(waits), 32'd0);
      end
      cpu_valid = 1'b1; cpu_write = 1'b1; cpu_addr = 32'h0000_1040; cpu_wdata = 32'h1104;
      for (int c = 0; c < 3; c++) begin
         #1;
         chk("R8", $sformatf("full stall cycle %0d", c), {31'b0, cpu_ready}, 32'd0);
         @(negedge clk);
      end
      bus_ready = 1'b1;
      #1;
      chk("R6", "accept on retire", {31'b0, cpu_ready}, 32'd1);
      chk("R6", "retiring head", bus_addr, 32'h0000_1000);
      @(negedge clk);
      cpu_valid = 1'b0;
      repeat (6) @(negedge clk);
      bus_ready = 1'b0;
      chk("R6", "drain count", 32'(log_n), 32'd5);
      for (int k = 0; k < 5; k++) begin
         chk_log("R6", k, 32'h0000_1000 + 32'(16 * k), 1'b1);
         chk("R6", $sformatf("log[%0d] data", k), log_d[k], 32'h1100 + 32'(k));
      end
      chk("R10", "empty after drain", {31'b0, queue_empty}, 32'd1);

      // Non-matching load passes (R7)
      log_n = 0;
      for (int k = 0; k < 3; k++) cpu_op(32'h8000_2000 + 32'(4 * k), 32'h2200 + 32'(k), 1'b1, rd, waits);
      bus_ready = 1'b1;
      cpu_op(32'h8000_3000, 32'h0, 1'b0, rd, waits);
      repeat (4) @(negedge clk);
      bus_ready = 1'b0;
      chk("R7", "pass load waits", 32'(waits), 32'd0);
      chk("R7", "pass load data", rd, ~32'h8000_3000);
      chk_log("R7", 0, 32'h8000_3000, 1'b0);
      for (int k = 0; k < 3; k++) chk_log("R7", k + 1, 32'h8000_2000 + 32'(4 * k), 1'b1);

      // Matching load with low-bit offset (R5, R9)
      log_n = 0;
      for (int k = 0; k < 4; k++) cpu_op(32'h0000_4000 + 32'(4 * k), 32'h3300 + 32'(k), 1'b1, rd, waits);
      bus_ready = 1'b1;
      cpu_op(32'h0000_400A, 32'h0, 1'b0, rd, waits);
      repeat (4) @(negedge clk);
      bus_ready = 1'b0;
      chk("R5", "hit load waits", 32'(waits), 32'd3);
      chk("R9", "hit on offset address data", rd, ~32'h0000_400A);
      for (int k = 0; k < 3; k++) chk_log("R5", k, 32'h0000_4000 + 32'(4 * k), 1'b1);
      chk_log("R5", 3, 32'h0000_400A, 1'b0);
      chk_log("R5", 4, 32'h0000_400C, 1'b1);

      // Uncached access drains first (R4)
      log_n = 0;
      for (int k = 0; k < 2; k++) cpu_op(32'h0000_5000 + 32'(4 * k), 32'h4400 + 32'(k), 1'b1, rd, waits);
      bus_ready = 1'b1;
      cpu_op(32'hBFC0_0000, 32'h0, 1'b0, rd, waits);
      chk("R4", "uncached load waits", 32'(waits), 32'd2);
      chk("R4", "uncached load data", rd, ~32'hBFC0_0000);
      chk_log("R4", 0, 32'h0000_5000, 1'b1);
      chk_log("R4", 1, 32'h0000_5004, 1'b1);
      chk_log("R4", 2, 32'hBFC0_0000, 1'b0);
      cpu_op(32'hA000_0010, 32'h5555, 1'b1, rd, waits);
      #1;
      chk("R4", "uncached store on empty waits", 32'(waits), 32'd0);
      chk_log("R3", 3, 32'hA000_0010, 1'b1);
      chk("R3", "uncached store not queued", {31'b0, queue_empty}, 32'd1);
      @(negedge clk);
      bus_ready = 1'b0;

      // Upper-window store passes pending store (R7)
      log_n = 0;
      cpu_op(32'h0000_6000, 32'h6666, 1'b1, rd, waits);
      bus_ready = 1'b1;
      cpu_op(32'hC000_0100, 32'h7777, 1'b1, rd, waits);
      repeat (3) @(negedge clk);
      bus_ready = 1'b0;
      chk("R7", "upper store waits", 32'(waits), 32'd0);
      chk_log("R7", 0, 32'hC000_0100, 1'b1);
      chk_log("R7", 1, 32'h0000_6000, 1'b1);
      chk("R10", "empty at end", {31'b0, queue_empty}, 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule